// File: doc/BRIEF.md
# Synchronous DRAM Burst Sequencer

This block is the device-side burst logic of a two-bank, 16-bit synchronous DRAM. It receives already decoded read, write and burst-stop commands, each with a bank and a starting column. For every beat of a burst it works out the column address and reports it on the beat outputs. A write beat stores its data in the same cycle. A read beat puts the addressed word into an output pipeline, which presents it after the programmed read latency.

A mode register holds three settings: the read latency (1 to 3 clocks), the burst length (1, 2, 4, 8 or a full 256-column page) and the column order (sequential or interleaved). A new read or write can replace a running burst on any cycle. A stop command ends a running burst. Two byte masks stop the upper or lower byte of a write from being stored. The storage is a small register file. It holds one open row of 256 columns for each bank.

Top module: `sdram_burst_engine`

## Requirements
- R1: Read latency is set by mode_in[1:0], with legal values 1, 2 and 3. A read beat serviced in cycle c drives rdata with rdata_oe high in cycle c+L, where L is the latency, so the data appears L rising edges later.
- R2: A pulse on mode_we loads mode_in into the mode register in the next cycle. The fields are latency in [1:0], length code in [4:2] and order in [5] (1 means interleaved). The length codes are 0, 1, 2 and 3 for 1, 2, 4 and 8 beats, and 7 for full page. A write with latency 0, with length code 4, 5 or 6, or with interleaved order and full page is ignored, and the old mode stays in force. After reset the mode is latency 2, one beat, sequential.
- R3: In sequential order, beat k of a burst of length N starting at column s has column (s - s mod N) + ((s mod N) + k) mod N.
- R4: In interleaved order, beat k of a burst of length N starting at column s has column (s - s mod N) + ((s mod N) XOR k).
- R5: A burst of length 1, 2, 4 or 8 that is neither stopped nor replaced services exactly that many beats, on consecutive cycles, and then goes idle.
- R6: A full-page burst gives column (s + k) mod 256 on beat k. It keeps running past column 255 until a stop or a new command arrives.
- R7: A cycle that carries a stop and no read or write services no beat and ends the running burst. Read beats already in the pipeline still come out.
- R8: A read or write on any cycle, including a cycle inside a running burst, is serviced as beat 0 of a new burst in that same cycle, at the given bank and column. The new burst uses the current mode.
- R9: Write data is sampled in the cycle its beat is serviced, including the command cycle. It is stored at that beat's bank and column.
- R10: When dqm_hi is 1, bits 15:8 of a write beat are not stored. When dqm_lo is 1, bits 7:0 are not stored. Both masks are active high.
- R11: rdata_oe is low and rdata is zero in every cycle where no read beat is due. After reset, no beat is serviced and rdata_oe is low.
- R12: beat_valid, beat_wr, beat_bank and beat_col describe the beat serviced in the current cycle. At most one of cmd_rd, cmd_wr and cmd_stop is high in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Load mode_in into the mode register |
| mode_in | input | 6 | {order, length code[2:0], latency[1:0]} |
| cmd_rd | input | 1 | Read command |
| cmd_wr | input | 1 | Write command |
| cmd_stop | input | 1 | Burst-stop command |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_col | input | COL_W | Starting column of the command |
| wdata | input | 16 | Write data for the beat in this cycle |
| dqm_hi | input | 1 | Mask for the upper write byte |
| dqm_lo | input | 1 | Mask for the lower write byte |
| beat_valid | output | 1 | A beat is serviced this cycle |
| beat_wr | output | 1 | The serviced beat is a write |
| beat_bank | output | BANK_W | Bank of the serviced beat |
| beat_col | output | COL_W | Column of the serviced beat |
| rdata | output | 16 | Read data; zero when not driven |
| rdata_oe | output | 1 | Read data valid (output enable) |

## Verification
The latency properties assume that the latency field does not change while a read beat is still in the pipeline. The stimulus therefore writes a new mode only after enough idle cycles to empty the pipeline. The command properties assume that at most one of read, write and stop is high in a cycle, and the bench never drives two of them together. Before the sweep of every latency, length and order, and before any readback, the bench fills both banks completely with full-page writes. Every read therefore returns a known value.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
    localparam logic [2:0] BLC_FULL = 3'd7;

    typedef struct packed {
        logic       ilv;
        logic [2:0] blc;
        logic [1:0] lat;
    } mode_t;

    localparam mode_t MODE_RESET = '{ilv: 1'b0, blc: 3'd0, lat: 2'd2};

    function automatic logic mode_ok(mode_t m);
        logic len_ok;
        len_ok = (m.blc <= 3'd3) || (m.blc == BLC_FULL);
        return len_ok && (m.lat != 2'd0) && !(m.ilv && (m.blc == BLC_FULL));
    endfunction
endpackage

// File: rtl/sdb_colgen.sv
module sdb_colgen
    import sdb_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] idx,
    input  logic [2:0]       blc,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] walk;

    always_comb begin
        if (blc == BLC_FULL) mask = '1;
        else                 mask = (COL_W'(1) << blc) - COL_W'(1);
        walk = ilv ? (start ^ idx) : (start + idx);
        col  = (start & ~mask) | (walk & mask);
    end
endmodule

// File: rtl/sdb_array.sv
module sdb_array #(
    parameter int BANK_W = 1,
    parameter int COL_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [DATA_W/8-1:0]   be,
    input  logic [BANK_W-1:0]     bank,
    input  logic [COL_W-1:0]      col,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata
);
    localparam int NB    = DATA_W / 8;
    localparam int DEPTH = 1 << (BANK_W + COL_W);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [BANK_W+COL_W-1:0] addr;

    assign addr  = {bank, col};
    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NB; b++) begin
                if (be[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/sdb_rdpipe.sv
module sdb_rdpipe #(
    parameter int DATA_W  = 16,
    parameter int MAX_LAT = 3,
    parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  lat,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic [MAX_LAT-1:0]             v;
        logic [MAX_LAT-1:0][DATA_W-1:0] d;
    } pipe_t;

    pipe_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.v[0] = in_valid;
        s_d.d[0] = in_data;
        for (int i = 1; i < MAX_LAT; i++) begin
            s_d.v[i] = s_q.v[i-1];
            s_d.d[i] = s_q.d[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        if (lat != '0 && lat <= LAT_W'(MAX_LAT)) begin
            out_valid = s_q.v[lat - LAT_W'(1)];
            out_data  = s_q.d[lat - LAT_W'(1)];
        end
    end

    // R1: a read beat surfaces exactly the programmed number of edges later
    assert_lat1_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lat == LAT_W'(1)) |=> out_valid);
    assert_lat2_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lat == LAT_W'(2)) |=> ##1 out_valid);
    assert_lat3_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lat == LAT_W'(3)) |=> ##2 out_valid);
endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
    import sdb_pkg::*;
#(
    parameter int BANK_W = 1,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [5:0]        mode_in,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic              cmd_stop,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [15:0]       wdata,
    input  logic              dqm_hi,
    input  logic              dqm_lo,
    output logic              beat_valid,
    output logic              beat_wr,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col,
    output logic [15:0]       rdata,
    output logic              rdata_oe
);
    localparam int DATA_W  = 16;
    localparam int MAX_LAT = 3;

    typedef struct packed {
        logic              act;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  start;
        logic [COL_W-1:0]  idx;
        logic [2:0]        blc;
        logic              ilv;
        mode_t             mode;
    } st_t;

    st_t st_d, st_q;

    logic              new_cmd;
    logic [COL_W-1:0]  sel_start, sel_idx, last_idx;
    logic [2:0]        sel_blc;
    logic              sel_ilv;
    logic [DATA_W-1:0] arr_rdata, pipe_data;
    logic              pipe_valid;

    always_comb begin
        new_cmd    = cmd_rd | cmd_wr;
        beat_valid = new_cmd | (st_q.act & ~cmd_stop);
        if (new_cmd) begin
            beat_wr   = cmd_wr;
            beat_bank = cmd_bank;
            sel_start = cmd_col;
            sel_idx   = '0;
            sel_blc   = st_q.mode.blc;
            sel_ilv   = st_q.mode.ilv;
        end else begin
            beat_wr   = st_q.wr;
            beat_bank = st_q.bank;
            sel_start = st_q.start;
            sel_idx   = st_q.idx;
            sel_blc   = st_q.blc;
            sel_ilv   = st_q.ilv;
        end
        last_idx = (COL_W'(1) << st_q.blc) - COL_W'(1);

        st_d = st_q;
        if (new_cmd) begin
            st_d.act   = (st_q.mode.blc != 3'd0);
            st_d.wr    = cmd_wr;
            st_d.bank  = cmd_bank;
            st_d.start = cmd_col;
            st_d.idx   = COL_W'(1);
            st_d.blc   = st_q.mode.blc;
            st_d.ilv   = st_q.mode.ilv;
        end else if (cmd_stop) begin
            st_d.act = 1'b0;
        end else if (st_q.act) begin
            st_d.idx = st_q.idx + COL_W'(1);
            if (st_q.blc != BLC_FULL && st_q.idx == last_idx) st_d.act = 1'b0;
        end
        if (mode_we && mode_ok(mode_t'(mode_in))) st_d.mode = mode_t'(mode_in);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    sdb_colgen #(.COL_W(COL_W)) u_colgen (
        .start (sel_start),
        .idx   (sel_idx),
        .blc   (sel_blc),
        .ilv   (sel_ilv),
        .col   (beat_col)
    );

    sdb_array #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (beat_valid & beat_wr),
        .be    ({~dqm_hi, ~dqm_lo}),
        .bank  (beat_bank),
        .col   (beat_col),
        .wdata (wdata),
        .rdata (arr_rdata)
    );

    sdb_rdpipe #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT), .LAT_W(2)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat       (st_q.mode.lat),
        .in_valid  (beat_valid & ~beat_wr),
        .in_data   (arr_rdata),
        .out_valid (pipe_valid),
        .out_data  (pipe_data)
    );

    assign rdata_oe = pipe_valid;
    assign rdata    = pipe_valid ? pipe_data : '0;

    // R12: input rule, at most one command per cycle
    assert_single_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_rd, cmd_wr, cmd_stop}));
    // R2: interleaved full page is refused
    assert_ilv_full_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_in[5] && mode_in[4:2] == 3'd7) |=> $stable(st_q.mode));
    // R7: stop leaves nothing to service next cycle
    assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !new_cmd) |=> (!beat_valid || cmd_rd || cmd_wr));
    // R5: single-beat burst ends at once
    assert_len1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cmd && st_q.mode.blc == 3'd0) |=> (!beat_valid || cmd_rd || cmd_wr));
    // R3 and R4: continuation beats stay within the aligned block
    assert_stay_in_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !new_cmd && st_q.blc != BLC_FULL) |->
        ((beat_col >> st_q.blc) == (st_q.start >> st_q.blc)));
    // R8: a new command is serviced in its own cycle at its own address
    assert_start_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
        new_cmd |-> (beat_valid && beat_col == cmd_col && beat_bank == cmd_bank));
endmodule

// File: tb/sim_sdram_burst_engine.sv
module sim_sdram_burst_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [5:0]  mode_in = '0;
    logic        cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_stop = 1'b0;
    logic [0:0]  cmd_bank = '0;
    logic [7:0]  cmd_col = '0;
    logic [15:0] wdata = '0;
    logic        dqm_hi = 1'b0, dqm_lo = 1'b0;
    logic        beat_valid, beat_wr, rdata_oe;
    logic [0:0]  beat_bank;
    logic [7:0]  beat_col;
    logic [15:0] rdata;

    always #10 clk = ~clk;

    sdram_burst_engine u0 (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_stop(cmd_stop),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .wdata(wdata),
        .dqm_hi(dqm_hi), .dqm_lo(dqm_lo), .beat_valid(beat_valid),
        .beat_wr(beat_wr), .beat_bank(beat_bank), .beat_col(beat_col),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    string ctx = "R11 reset";
    int m_lat = 2, m_blc = 0, m_ilv = 0;
    int b_act = 0, b_wr = 0, b_bank = 0, b_start = 0, b_idx = 0, b_blc = 0, b_ilv = 0;
    logic [15:0] mm [2][256];
    int          due_q [$];
    logic [15:0] dat_q [$];

    function automatic logic [15:0] pat(int c);
        return 16'((c * 40503) ^ 23130);
    endfunction

    function automatic int col_of(int s, int k, int blc, int ilv);
        int len, base, off;
        if (blc == 7) return (s + k) % 256;
        len  = 1 << blc;
        off  = s % len;
        base = s - off;
        if (ilv != 0) return base + (off ^ k);
        return base + (off + k) % len;
    endfunction

    task automatic step(input bit rd, input bit wr, input bit stp, input bit bk,
                        input logic [7:0] col, input logic [15:0] wd,
                        input bit hi, input bit lo, input bit mwe, input logic [5:0] min);
        int ev, ew, eb, ec, eo;
        logic [15:0] ed;
        @(negedge clk);
        cmd_rd = rd; cmd_wr = wr; cmd_stop = stp; cmd_bank = bk; cmd_col = col;
        wdata = wd; dqm_hi = hi; dqm_lo = lo; mode_we = mwe; mode_in = min;
        #3;
        ev = 0; ew = 0; eb = 0; ec = 0;
        if (rd || wr) begin ev = 1; ew = wr; eb = bk; ec = col; end
        else if (!stp && b_act != 0) begin
            ev = 1; ew = b_wr; eb = b_bank; ec = col_of(b_start, b_idx, b_blc, b_ilv);
        end
        n_chk++;
        if (beat_valid !== 1'(ev) || (ev != 0 && (beat_wr !== 1'(ew) ||
            beat_bank !== 1'(eb) || beat_col !== 8'(ec)))) begin
            n_fail++;
            $display("FAIL R12 %s cyc %0d beat: got v=%0d w=%0d b=%0d c=%0d exp v=%0d w=%0d b=%0d c=%0d",
                     ctx, cyc, beat_valid, beat_wr, beat_bank, beat_col, ev, ew, eb, ec);
        end
        eo = 0; ed = '0;
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            eo = 1; ed = dat_q[0];
            void'(due_q.pop_front()); void'(dat_q.pop_front());
        end
        n_chk++;
        if (rdata_oe !== 1'(eo) || rdata !== ed) begin
            n_fail++;
            $display("FAIL R1/R11 %s cyc %0d read: got oe=%0d d=%h exp oe=%0d d=%h",
                     ctx, cyc, rdata_oe, rdata, eo, ed);
        end
        @(posedge clk);
        if (ev != 0 && ew == 0) begin
            due_q.push_back(cyc + m_lat);
            dat_q.push_back(mm[eb][ec]);
        end
        if (ev != 0 && ew != 0) begin
            if (!hi) mm[eb][ec][15:8] = wd[15:8];
            if (!lo) mm[eb][ec][7:0]  = wd[7:0];
        end
        if (rd || wr) begin
            b_act = (m_blc != 0); b_idx = 1; b_wr = wr; b_bank = bk;
            b_start = col; b_blc = m_blc; b_ilv = m_ilv;
        end else if (stp) begin
            b_act = 0;
        end else if (b_act != 0) begin
            b_idx++;
            if (b_blc != 7 && b_idx == (1 << b_blc)) b_act = 0;
        end
        if (mwe && min[1:0] != 0 && (min[4:2] <= 3 || min[4:2] == 7) &&
            !(min[5] && min[4:2] == 7)) begin
            m_lat = min[1:0]; m_blc = min[4:2]; m_ilv = min[5];
        end
        cyc++;
    endtask

    task automatic idle(int n);
        repeat (n) step(0, 0, 0, 0, 8'd0, pat(cyc), 0, 0, 0, 6'd0);
    endtask
    task automatic rd_cmd(bit bk, logic [7:0] c);
        step(1, 0, 0, bk, c, pat(cyc), 0, 0, 0, 6'd0);
    endtask
    task automatic wr_cmd(bit bk, logic [7:0] c, bit hi, bit lo);
        step(0, 1, 0, bk, c, pat(cyc), hi, lo, 0, 6'd0);
    endtask
    task automatic wr_beat(bit hi, bit lo);
        step(0, 0, 0, 0, 8'd0, pat(cyc), hi, lo, 0, 6'd0);
    endtask
    task automatic stop_cmd();
        step(0, 0, 1, 0, 8'd0, pat(cyc), 0, 0, 0, 6'd0);
    endtask
    task automatic set_mode(int lat, int blc, int ilv);
        step(0, 0, 0, 0, 8'd0, pat(cyc), 0, 0, 1, {1'(ilv), 3'(blc), 2'(lat)});
    endtask

    initial begin
        #(64'd20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL R12 watchdog expired at cyc %0d: got running exp finished", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #3;
        n_chk++;
        if (beat_valid !== 1'b0 || rdata_oe !== 1'b0 || rdata !== 16'h0) begin
            n_fail++;
            $display("FAIL R11 reset: got v=%0d oe=%0d d=%h exp v=0 oe=0 d=0000",
                     beat_valid, rdata_oe, rdata);
        end
        idle(2);

        ctx = "R6 R9 full page fill";
        set_mode(2, 7, 0);
        wr_cmd(0, 8'd250, 0, 0); idle(257); stop_cmd(); idle(2);
        wr_cmd(1, 8'd0, 0, 0);   idle(255); stop_cmd(); idle(2);

        ctx = "R2 rejected mode";
        set_mode(3, 7, 1); set_mode(0, 1, 0); set_mode(2, 5, 0);
        rd_cmd(0, 8'd10); idle(5); stop_cmd(); idle(4);

        ctx = "R3 R4 R5 R1 sweep";
        for (int lat = 1; lat <= 3; lat++)
            for (int blc = 0; blc <= 3; blc++)
                for (int ilv = 0; ilv <= 1; ilv++) begin
                    set_mode(lat, blc, ilv);
                    rd_cmd(1'(lat), 8'(8'h35 + blc * 17 + ilv * 5));
                    idle((1 << blc) + lat + 1);
                end

        ctx = "R9 R10 masked write";
        set_mode(2, 2, 1);
        wr_cmd(1, 8'h46, 1, 0); wr_beat(0, 1); wr_beat(1, 1); wr_beat(0, 0);
        idle(1); rd_cmd(1, 8'h46); idle(6);

        ctx = "R8 interrupt";
        set_mode(1, 3, 0);
        rd_cmd(0, 8'd3); idle(2); rd_cmd(1, 8'd200); idle(1);
        wr_cmd(0, 8'd100, 0, 0); idle(3); rd_cmd(0, 8'd100); idle(10);

        ctx = "R7 stop";
        set_mode(3, 3, 1);
        rd_cmd(0, 8'd60); idle(2); stop_cmd(); idle(5);
        wr_cmd(1, 8'd17, 0, 0); idle(1); stop_cmd(); idle(2);
        rd_cmd(1, 8'd16); idle(12);

        ctx = "R6 R8 full page interrupted";
        set_mode(1, 7, 0);
        rd_cmd(1, 8'd254); idle(4); rd_cmd(0, 8'd0); idle(3); stop_cmd(); idle(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule